// File: doc/BRIEF.md
# Pipeline Stall Accounting Unit

This block watches the stream of retired instructions of a simple in-order core and keeps performance statistics about the stalls that stream would cause. Each retired instruction arrives with its unit class, up to two source register indices with valid flags, a destination index used by loads, a taken flag for control transfers, and two markers that delimit a group of instructions issued together. No pipeline is actually stalled. The block only counts.

Stalls come from two sources. A source operand that was written by a load in the group just before it costs two cycles. A taken control transfer costs two cycles. The block records load destinations in a pending set. When the next group starts, that set replaces the active bitmap, and the active bitmap is what operands are tested against. Load-use and branch stall cycles are summed over a group and added to the counters only when the group's last instruction retires. The taken and not-taken branch counters move with each instruction. All counters saturate. A synchronous clear input empties every counter and both bitmaps.

Top module: `stall_acct`

## Requirements
- R1: A synchronous reset or a high `clear` sets all four counters, the active bitmap and the pending set to zero at the next clock edge. If `clear` coincides with an instruction, the instruction has no effect.
- R2: Unit codes are 0 execute, 1 compare, 2 multiply-accumulate, 3 control transfer, 4 load and 5 store. For classes 0 to 2, each valid source whose register is set in the active bitmap adds 2 to the load-stall total. A register named by both sources counts twice.
- R3: A source does not stall if its valid flag is low, if its index is all ones (31, meaning "none"), or if its index is 16 or above.
- R4: A control transfer tests only source A for a load stall. When taken, it adds 2 branch-stall cycles and increments the taken counter. When not taken, it increments the not-taken counter.
- R5: A load marks its destination register in the pending set. When an instruction with `firstOfSet` high retires, the pending set replaces the active bitmap, and the pending set restarts with that instruction's own mark. The active bitmap appears on `activeMap`.
- R6: A store, and the unused unit codes 6 and 7, change no counter.
- R7: Load-stall and branch-stall cycles gathered over a group are added to their counters only in the cycle whose instruction has `lastOfSet` high. The taken and not-taken counters update for each instruction. A later slot of a group tests against the active bitmap and does not see loads made earlier in the same group.
- R8: Every counter stops at its all-ones value instead of wrapping.
- R9: All outputs are registered. They show the effect of an instruction one clock after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Synchronous clear of counters and bitmaps |
| instValid | input | 1 | A retired instruction is presented |
| unitType | input | 3 | Unit class code (see R2) |
| srcA | input | IDX_W (5) | First source register index, 31 = none |
| srcAValid | input | 1 | First source is used |
| srcB | input | IDX_W (5) | Second source register index, 31 = none |
| srcBValid | input | 1 | Second source is used |
| dstIdx | input | MAP_IDX_W (4) | Load destination register |
| taken | input | 1 | Control transfer was taken |
| firstOfSet | input | 1 | Instruction opens an issue group |
| lastOfSet | input | 1 | Instruction closes an issue group |
| loadStallCycles | output | CNT_W (32) | Load-use stall cycles |
| branchStallCycles | output | CNT_W (32) | Taken-branch stall cycles |
| takenCount | output | CNT_W (32) | Taken control transfers |
| notTakenCount | output | CNT_W (32) | Not-taken control transfers |
| activeMap | output | NUM_REGS (16) | Registers currently treated as load-pending |

## Verification
Each counter and the active bitmap settle exactly one clock after the edge that samples an instruction or a clear. The bench therefore drives inputs on a falling edge and compares all five outputs on the next falling edge. A group spans several cycles, so the stall totals are checked in the middle of the group, where they must be unchanged, and again one cycle after the closing instruction, where they must include the whole group. Saturation is checked on a second instance with narrow counters, one cycle after the increment that would overflow.

// File: rtl/stall_acct_pkg.sv
package stall_acct_pkg;

  typedef enum logic [2:0] {
    UNIT_EXEC  = 3'd0,
    UNIT_CMP   = 3'd1,
    UNIT_MAC   = 3'd2,
    UNIT_CTI   = 3'd3,
    UNIT_LOAD  = 3'd4,
    UNIT_STORE = 3'd5
  } unit_e;

  // Strobes from control to datapath, one cycle's worth of work.
  typedef struct packed {
    logic clearAll;   // wipe counters and bitmaps
    logic newSet;     // instruction opens a group: rotate pending into active
    logic endSet;     // instruction closes a group: commit stall totals
    logic chkA;       // test source A against active bitmap
    logic chkB;       // test source B against active bitmap
    logic brTaken;    // taken control transfer
    logic brNotTaken; // not-taken control transfer
    logic loadMark;   // record destination in pending set
  } stall_strobe_t;

endpackage

// File: rtl/stall_acct_ctrl.sv
module stall_acct_ctrl
  import stall_acct_pkg::*;
(
  input  logic          clear,
  input  logic          instValid,
  input  logic [2:0]    unitType,
  input  logic          srcAValid,
  input  logic          srcBValid,
  input  logic          taken,
  input  logic          firstOfSet,
  input  logic          lastOfSet,
  output stall_strobe_t strobe
);

  always_comb begin
    strobe          = '0;
    strobe.clearAll = clear;
    if (instValid && !clear) begin
      strobe.newSet = firstOfSet;
      strobe.endSet = lastOfSet;
      case (unitType)
        UNIT_EXEC, UNIT_CMP, UNIT_MAC: begin
          strobe.chkA = srcAValid;
          strobe.chkB = srcBValid;
        end
        UNIT_CTI: begin
          strobe.chkA       = srcAValid;
          strobe.brTaken    = taken;
          strobe.brNotTaken = !taken;
        end
        UNIT_LOAD: strobe.loadMark = 1'b1;
        default: ;  // store and unused codes: group markers only
      endcase
    end
  end

endmodule

// File: rtl/stall_acct_dp.sv
module stall_acct_dp
  import stall_acct_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int CNT_W     = 32,
  parameter int MAP_IDX_W = 4,
  parameter int IDX_W     = 5,
  parameter int ACC_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  stall_strobe_t        strobe,
  input  logic [IDX_W-1:0]     srcA,
  input  logic [IDX_W-1:0]     srcB,
  input  logic [MAP_IDX_W-1:0] dstIdx,
  output logic [CNT_W-1:0]     loadStallCycles,
  output logic [CNT_W-1:0]     branchStallCycles,
  output logic [CNT_W-1:0]     takenCount,
  output logic [CNT_W-1:0]     notTakenCount,
  output logic [NUM_REGS-1:0]  activeMap
);

  localparam logic [ACC_W-1:0] STALL_PENALTY = ACC_W'(2);

  logic [NUM_REGS-1:0] pendMap;
  logic [NUM_REGS-1:0] checkMap;
  logic [NUM_REGS-1:0] markMask;
  logic [ACC_W-1:0]    accLoad, accBranch;
  logic [ACC_W-1:0]    sumLoad, sumBranch;
  logic                hitA, hitB;

  // Only indices below NUM_REGS can match; "none" (all ones) never does.
  function automatic logic srcHit(input logic [IDX_W-1:0] idx,
                                  input logic [NUM_REGS-1:0] map);
    logic h;
    h = 1'b0;
    for (int r = 0; r < NUM_REGS; r++)
      if (idx == IDX_W'(r)) h = map[r];
    return h;
  endfunction

  function automatic logic [CNT_W-1:0] satAdd(input logic [CNT_W-1:0] a,
                                              input logic [ACC_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + (CNT_W+1)'(b);
    return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
  endfunction

  // A group's opener sees the pending set as it is about to become active.
  assign checkMap = strobe.newSet ? pendMap : activeMap;
  assign hitA     = strobe.chkA && srcHit(srcA, checkMap);
  assign hitB     = strobe.chkB && srcHit(srcB, checkMap);
  assign markMask = strobe.loadMark ? (NUM_REGS'(1) << dstIdx) : '0;

  always_comb begin
    sumLoad   = strobe.newSet ? '0 : accLoad;
    sumBranch = strobe.newSet ? '0 : accBranch;
    if (hitA)           sumLoad   = sumLoad + STALL_PENALTY;
    if (hitB)           sumLoad   = sumLoad + STALL_PENALTY;
    if (strobe.brTaken) sumBranch = sumBranch + STALL_PENALTY;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clearAll) begin
      activeMap         <= '0;
      pendMap           <= '0;
      accLoad           <= '0;
      accBranch         <= '0;
      loadStallCycles   <= '0;
      branchStallCycles <= '0;
      takenCount        <= '0;
      notTakenCount     <= '0;
    end else begin
      if (strobe.newSet) begin
        activeMap <= pendMap;
        pendMap   <= markMask;
      end else begin
        pendMap   <= pendMap | markMask;
      end

      if (strobe.endSet) begin
        loadStallCycles   <= satAdd(loadStallCycles, sumLoad);
        branchStallCycles <= satAdd(branchStallCycles, sumBranch);
        accLoad           <= '0;
        accBranch         <= '0;
      end else begin
        accLoad   <= sumLoad;
        accBranch <= sumBranch;
      end

      if (strobe.brTaken)    takenCount    <= satAdd(takenCount, ACC_W'(1));
      if (strobe.brNotTaken) notTakenCount <= satAdd(notTakenCount, ACC_W'(1));
    end
  end

endmodule

// File: rtl/stall_acct.sv
module stall_acct
  import stall_acct_pkg::*;
#(
  parameter  int NUM_REGS  = 16,
  parameter  int CNT_W     = 32,
  localparam int MAP_IDX_W = $clog2(NUM_REGS),
  localparam int IDX_W     = MAP_IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 instValid,
  input  logic [2:0]           unitType,
  input  logic [IDX_W-1:0]     srcA,
  input  logic                 srcAValid,
  input  logic [IDX_W-1:0]     srcB,
  input  logic                 srcBValid,
  input  logic [MAP_IDX_W-1:0] dstIdx,
  input  logic                 taken,
  input  logic                 firstOfSet,
  input  logic                 lastOfSet,
  output logic [CNT_W-1:0]     loadStallCycles,
  output logic [CNT_W-1:0]     branchStallCycles,
  output logic [CNT_W-1:0]     takenCount,
  output logic [CNT_W-1:0]     notTakenCount,
  output logic [NUM_REGS-1:0]  activeMap
);

  stall_strobe_t strobe;

  stall_acct_ctrl u_ctrl (
    .clear      (clear),
    .instValid  (instValid),
    .unitType   (unitType),
    .srcAValid  (srcAValid),
    .srcBValid  (srcBValid),
    .taken      (taken),
    .firstOfSet (firstOfSet),
    .lastOfSet  (lastOfSet),
    .strobe     (strobe)
  );

  stall_acct_dp #(
    .NUM_REGS  (NUM_REGS),
    .CNT_W     (CNT_W),
    .MAP_IDX_W (MAP_IDX_W),
    .IDX_W     (IDX_W)
  ) u_dp (
    .clk               (clk),
    .rst               (rst),
    .strobe            (strobe),
    .srcA              (srcA),
    .srcB              (srcB),
    .dstIdx            (dstIdx),
    .loadStallCycles   (loadStallCycles),
    .branchStallCycles (branchStallCycles),
    .takenCount        (takenCount),
    .notTakenCount     (notTakenCount),
    .activeMap         (activeMap)
  );

endmodule

// File: rtl/stall_acct_chk.sv
module stall_acct_chk #(
  parameter  int NUM_REGS  = 16,
  parameter  int CNT_W     = 32,
  localparam int MAP_IDX_W = $clog2(NUM_REGS),
  localparam int IDX_W     = MAP_IDX_W + 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 clear,
  input logic                 instValid,
  input logic [2:0]           unitType,
  input logic [IDX_W-1:0]     srcA,
  input logic                 srcAValid,
  input logic [IDX_W-1:0]     srcB,
  input logic                 srcBValid,
  input logic [MAP_IDX_W-1:0] dstIdx,
  input logic                 taken,
  input logic                 firstOfSet,
  input logic                 lastOfSet,
  input logic [CNT_W-1:0]     loadStallCycles,
  input logic [CNT_W-1:0]     branchStallCycles,
  input logic [CNT_W-1:0]     takenCount,
  input logic [CNT_W-1:0]     notTakenCount,
  input logic [NUM_REGS-1:0]  activeMap
);

  logic singleOp;
  assign singleOp = instValid && firstOfSet && lastOfSet && !clear;

  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (rst)
    clear |=> (loadStallCycles == '0 && branchStallCycles == '0 &&
               takenCount == '0 && notTakenCount == '0 && activeMap == '0));

  assert_none_src_R3: assert property (@(posedge clk) disable iff (rst)
    (singleOp && unitType == 3'd0 &&
     (!srcAValid || srcA == '1) && (!srcBValid || srcB == '1))
    |=> $stable(loadStallCycles));

  assert_taken_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!clear && !(instValid && unitType == 3'd3 && taken)) |=> $stable(takenCount));

  assert_not_taken_step_R4: assert property (@(posedge clk) disable iff (rst)
    (instValid && !clear && unitType == 3'd3 && !taken && notTakenCount != '1)
    |=> notTakenCount == $past(notTakenCount) + 1'b1);

  assert_map_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!clear && !(instValid && firstOfSet)) |=> $stable(activeMap));

  assert_store_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (singleOp && unitType == 3'd5)
    |=> ($stable(loadStallCycles) && $stable(branchStallCycles) &&
         $stable(takenCount) && $stable(notTakenCount)));

  assert_defer_commit_R7: assert property (@(posedge clk) disable iff (rst)
    (!clear && !(instValid && lastOfSet))
    |=> ($stable(loadStallCycles) && $stable(branchStallCycles)));

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (!clear && branchStallCycles == '1) |=> branchStallCycles == '1);

endmodule

bind stall_acct stall_acct_chk #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/stall_acct_bench.sv
module stall_acct_bench;

  localparam int NUM_REGS = 16;
  localparam int IDX_W    = 5;
  localparam int NARROW_W = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic             rst, clear, instValid, srcAValid, srcBValid, taken;
  logic             firstOfSet, lastOfSet;
  logic [2:0]       unitType;
  logic [IDX_W-1:0] srcA, srcB;
  logic [3:0]       dstIdx;
  logic [31:0]      loadStall, branchStall, takenCnt, notTakenCnt;
  logic [15:0]      activeMap;
  logic [NARROW_W-1:0] nLoad, nBranch, nTaken, nNot;
  logic [15:0]      nMap;

  int checks = 0;
  int errors = 0;

  stall_acct u_stall_acct (
    .clk(clk), .rst(rst), .clear(clear), .instValid(instValid),
    .unitType(unitType), .srcA(srcA), .srcAValid(srcAValid),
    .srcB(srcB), .srcBValid(srcBValid), .dstIdx(dstIdx), .taken(taken),
    .firstOfSet(firstOfSet), .lastOfSet(lastOfSet),
    .loadStallCycles(loadStall), .branchStallCycles(branchStall),
    .takenCount(takenCnt), .notTakenCount(notTakenCnt), .activeMap(activeMap)
  );

  stall_acct #(.NUM_REGS(NUM_REGS), .CNT_W(NARROW_W)) u_stall_acct_narrow (
    .clk(clk), .rst(rst), .clear(clear), .instValid(instValid),
    .unitType(unitType), .srcA(srcA), .srcAValid(srcAValid),
    .srcB(srcB), .srcBValid(srcBValid), .dstIdx(dstIdx), .taken(taken),
    .firstOfSet(firstOfSet), .lastOfSet(lastOfSet),
    .loadStallCycles(nLoad), .branchStallCycles(nBranch),
    .takenCount(nTaken), .notTakenCount(nNot), .activeMap(nMap)
  );

  typedef struct packed {
    logic [2:0] u; logic [4:0] a; logic av; logic [4:0] b; logic bv;
    logic [3:0] d; logic tk; logic f; logic l;
    logic [15:0] eL, eB, eT, eN, eM;
  } vec_t;

  function automatic vec_t mk(input int u, a, av, b, bv, d, tk, f, l,
                              input int eL, eB, eT, eN, eM);
    vec_t v;
    v.u = 3'(u); v.a = 5'(a); v.av = 1'(av); v.b = 5'(b); v.bv = 1'(bv);
    v.d = 4'(d); v.tk = 1'(tk); v.f = 1'(f); v.l = 1'(l);
    v.eL = 16'(eL); v.eB = 16'(eB); v.eT = 16'(eT); v.eN = 16'(eN); v.eM = 16'(eM);
    return v;
  endfunction

  // unit, srcA, aV, srcB, bV, dst, taken, first, last | load, branch, taken, notTaken, map
  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    mk(4, 31,0, 31,0,  3, 0, 1,1,   0,0,0,0, 'h0000), // R5 load marks r3
    mk(0,  3,1,  5,1,  0, 0, 1,1,   2,0,0,0, 'h0008), // R2 exec hit
    mk(0,  3,1, 31,0,  0, 0, 1,1,   2,0,0,0, 'h0000), // R5 map replaced
    mk(4, 31,0, 31,0,  7, 0, 1,1,   2,0,0,0, 'h0000),
    mk(3,  7,1, 31,0,  0, 1, 1,1,   4,2,1,0, 'h0080), // R4 taken + load hit
    mk(4, 31,0, 31,0,  2, 0, 1,1,   4,2,1,0, 'h0000),
    mk(1,  2,1,  2,1,  0, 0, 1,1,   8,2,1,0, 'h0004), // R2 compare, both hit
    mk(4, 31,0, 31,0,  9, 0, 1,1,   8,2,1,0, 'h0000),
    mk(2, 31,1,  9,1,  0, 0, 1,1,  10,2,1,0, 'h0200), // R3 none + R2 mac hit
    mk(4, 31,0, 31,0,  4, 0, 1,1,  10,2,1,0, 'h0000),
    mk(5,  4,1,  4,1,  0, 0, 1,1,  10,2,1,0, 'h0010), // R6 store quiet
    mk(4, 31,0, 31,0,  6, 0, 1,1,  10,2,1,0, 'h0000),
    mk(0,  6,0, 31,0,  0, 0, 1,1,  10,2,1,0, 'h0040), // R3 invalid flag
    mk(3, 31,1, 31,0,  0, 0, 1,1,  10,2,1,1, 'h0000), // R4 not taken
    mk(4, 31,0, 31,0,  1, 0, 1,0,  10,2,1,1, 'h0000), // R7 group opener load
    mk(0,  1,1, 31,0,  0, 0, 0,1,  10,2,1,1, 'h0000), // R7 partner not seen
    mk(4, 31,0, 31,0, 12, 0, 1,1,  10,2,1,1, 'h0002),
    mk(0, 12,1, 31,0,  0, 0, 1,0,  10,2,1,1, 'h1000), // R7 deferred
    mk(3, 12,1, 31,0,  0, 1, 0,1,  14,4,2,1, 'h1000), // R7 commit
    mk(3, 31,0, 31,0,  0, 1, 1,0,  14,4,3,1, 'h0000), // R7 taken counts now
    mk(5, 31,0, 31,0,  0, 0, 0,1,  14,6,3,1, 'h0000)  // R7 branch commit
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag, input int eL, eB, eT, eN, eM);
    check({tag, " loadStall"},   loadStall,   32'(eL));
    check({tag, " branchStall"}, branchStall, 32'(eB));
    check({tag, " taken"},       takenCnt,    32'(eT));
    check({tag, " notTaken"},    notTakenCnt, 32'(eN));
    check({tag, " activeMap"},   {16'd0, activeMap}, 32'(eM));
  endtask

  task automatic idle();
    instValid = 1'b0; clear = 1'b0; unitType = 3'd0;
    srcA = 5'd31; srcB = 5'd31; srcAValid = 1'b0; srcBValid = 1'b0;
    dstIdx = 4'd0; taken = 1'b0; firstOfSet = 1'b0; lastOfSet = 1'b0;
  endtask

  // Drive at a falling edge; results are sampled one clock later (R9).
  task automatic step(input int u, a, av, b, bv, d, tk, f, l, clr);
    instValid = 1'b1; unitType = 3'(u); srcA = 5'(a); srcAValid = 1'(av);
    srcB = 5'(b); srcBValid = 1'(bv); dstIdx = 4'(d); taken = 1'(tk);
    firstOfSet = 1'(f); lastOfSet = 1'(l); clear = 1'(clr);
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkAll("R1 reset", 0, 0, 0, 0, 0);

    // Vector table: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NVEC; i++) begin
      step(int'(VECS[i].u), int'(VECS[i].a), int'(VECS[i].av), int'(VECS[i].b),
           int'(VECS[i].bv), int'(VECS[i].d), int'(VECS[i].tk), int'(VECS[i].f),
           int'(VECS[i].l), 0);
      checkAll($sformatf("R9 vec%0d", i), int'(VECS[i].eL), int'(VECS[i].eB),
               int'(VECS[i].eT), int'(VECS[i].eN), int'(VECS[i].eM));
    end

    // R6: unused unit codes do not stall even on a pending register
    step(4, 31,0, 31,0, 5, 0, 1,1, 0);
    step(6,  5,1,  5,1, 0, 1, 1,1, 0);
    step(7,  5,1,  5,1, 0, 1, 1,1, 0);
    checkAll("R6 unused codes", 14, 6, 3, 1, 0);

    // R3: out-of-range index 16 does not alias register 0
    step(4, 31,0, 31,0, 0, 0, 1,1, 0);
    step(0, 16,1, 16,1, 0, 0, 1,1, 0);
    checkAll("R3 index 16", 14, 6, 3, 1, 'h0001);

    // R1: clear wins over a taken branch, and empties the pending set
    step(4, 31,0, 31,0, 5, 0, 1,1, 0);
    step(3,  5,1, 31,0, 0, 1, 1,1, 1);
    checkAll("R1 clear", 0, 0, 0, 0, 0);
    step(0, 5,1, 31,0, 0, 0, 1,1, 0);
    checkAll("R1 pending cleared", 0, 0, 0, 0, 0);

    // R8: saturation on the narrow instance, wide one keeps counting
    for (int k = 0; k < 31; k++) step(3, 31,0, 31,0, 0, 1, 1,1, 0);
    check("R8 narrow branch before", {26'd0, nBranch}, 32'd62);
    check("R8 narrow taken before",  {26'd0, nTaken},  32'd31);
    for (int k = 0; k < 39; k++) step(3, 31,0, 31,0, 0, 1, 1,1, 0);
    check("R8 narrow branch sat", {26'd0, nBranch}, 32'd63);
    check("R8 narrow taken sat",  {26'd0, nTaken},  32'd63);
    check("R8 wide branch", branchStall, 32'd140);
    check("R8 wide taken",  takenCnt,    32'd70);
    check("R4 wide notTaken unchanged", notTakenCnt, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule